// File: doc/BRIEF.md
# Memory ECC Error Logger

This block sits beside a memory controller's datapath and records uncorrectable (multi-bit) ECC errors. The datapath raises a one-cycle error strobe with the failing address, whether the access was a read or a write, whether it came from an internal bus queue or a direct DMA port, and the identity of the requesting port. Two log slots keep the error type and the address of the first two unhandled errors. While either slot is occupied, an interrupt is driven to the processor.

The logger also issues the actions that every error calls for, whether or not it is logged. A failing read, with ECC checking enabled, produces a target-abort pulse toward the requester. A failing write can only come from the read phase of a read-modify-write for a partial write. For such an error the logger asks the datapath to write the merged data back with freshly generated check bits. The bad data then stays in memory, but its check bits agree with it.

Software frees a slot by writing a one to that slot's status bit. Slot 0 is always used before slot 1. When both slots are occupied, later errors are not recorded, but their abort or write-back action still takes place.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, `sts` is 00, `irq` is 0, `abort_valid` is 0 and `wb_regen` is 0.
- R2: An error strobe accepted while `rpt_en` is 1 sets the chosen slot's status bit, where `sts[0]` belongs to slot 0 and `sts[1]` to slot 1. It also stores the error's address and type in that slot. All of this is visible one cycle after the strobe. `irq` is 1 whenever any status bit is set.
- R3: A read error (`err_is_wr`=0) with `ecc_chk_en`=1 gives a one-cycle `abort_valid` pulse in the cycle after the strobe, with `abort_port` equal to `err_port`. With `ecc_chk_en`=0, or on a write error, no abort is given.
- R4: A write error (`err_is_wr`=1) gives a one-cycle `wb_regen` pulse in the cycle after the strobe, with `wb_addr` equal to `err_addr`.
- R5: When both slots are free, an error goes to slot 0. When slot 0 is occupied and slot 1 is free, it goes to slot 1.
- R6: When both slots are occupied, an error changes no slot's status, type or address. Its abort or write-back action still happens as in R3 and R4.
- R7: With `rpt_en`=0, an error writes no slot and raises no interrupt. A read abort still follows R3.
- R8: A cycle with `clr_valid`=1 clears each status bit whose `clr_mask` bit is 1 and leaves the others unchanged. `irq` falls once no bit remains set.
- R9: The slot for a capture is chosen from the status as it stood before that cycle's clear. When a clear and a capture hit the same slot in the same cycle, the capture wins and the bit ends up set.
- R10: The type field is 2 bits. Bit 1 is 1 for a write and 0 for a read. Bit 0 is 1 for a direct DMA port and 0 for an internal bus queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Multi-bit error strobe |
| err_addr | input | ADDR_W | Failing address |
| err_is_wr | input | 1 | 1 = error during a partial-write read phase |
| err_is_dma | input | 1 | 1 = direct DMA port, 0 = internal bus queue |
| err_port | input | PORT_W | Requesting port identity |
| ecc_chk_en | input | 1 | ECC checking enable |
| rpt_en | input | 1 | Error reporting enable |
| clr_valid | input | 1 | Status clear write strobe |
| clr_mask | input | 2 | Write-one-to-clear mask for the status bits |
| sts | output | 2 | Slot status bits |
| irq | output | 1 | Processor interrupt |
| slot0_type | output | 2 | Slot 0 error type |
| slot0_addr | output | ADDR_W | Slot 0 error address |
| slot1_type | output | 2 | Slot 1 error type |
| slot1_addr | output | ADDR_W | Slot 1 error address |
| abort_valid | output | 1 | Target-abort pulse |
| abort_port | output | PORT_W | Port that receives the abort |
| wb_regen | output | 1 | Request to write back with regenerated ECC |
| wb_addr | output | ADDR_W | Address for the write-back |

## Verification
A software clear and a new capture can land in the same cycle. The bench drives `clr_valid` together with an error strobe in two cases.

In the first case both slots are free and the mask covers slot 0. Capture must win, so the bench expects `sts`=01.

In the second case slot 0 is occupied and its clear arrives with the error. Slot choice uses the status before the clear, so the bench expects the error in slot 1 with slot 0 freed, giving `sts`=10. In both cases the stored address and the abort pulse are compared with the values the requirements predict.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_is_wr,
  input  logic              err_is_dma,
  input  logic [PORT_W-1:0] err_port,
  input  logic              ecc_chk_en,
  input  logic              rpt_en,
  input  logic              clr_valid,
  input  logic [1:0]        clr_mask,
  output logic [1:0]        sts,
  output logic              irq,
  output logic [1:0]        slot0_type,
  output logic [ADDR_W-1:0] slot0_addr,
  output logic [1:0]        slot1_type,
  output logic [ADDR_W-1:0] slot1_addr,
  output logic              abort_valid,
  output logic [PORT_W-1:0] abort_port,
  output logic              wb_regen,
  output logic [ADDR_W-1:0] wb_addr
);

  logic       log_req;
  logic       cap0, cap1;
  logic [1:0] clr;
  logic [1:0] err_type;

  assign log_req  = err_valid & rpt_en;
  assign cap0     = log_req & ~sts[0];
  assign cap1     = log_req & sts[0] & ~sts[1];
  assign clr      = clr_valid ? clr_mask : 2'b00;
  assign err_type = {err_is_wr, err_is_dma};
  assign irq      = |sts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts        <= 2'b00;
      slot0_type <= 2'b00;
      slot0_addr <= '0;
      slot1_type <= 2'b00;
      slot1_addr <= '0;
    end else begin
      sts[0] <= cap0 | (sts[0] & ~clr[0]);
      sts[1] <= cap1 | (sts[1] & ~clr[1]);
      if (cap0) begin
        slot0_type <= err_type;
        slot0_addr <= err_addr;
      end
      if (cap1) begin
        slot1_type <= err_type;
        slot1_addr <= err_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_valid <= 1'b0;
      abort_port  <= '0;
      wb_regen    <= 1'b0;
      wb_addr     <= '0;
    end else begin
      abort_valid <= err_valid & ~err_is_wr & ecc_chk_en;
      wb_regen    <= err_valid & err_is_wr;
      if (err_valid & ~err_is_wr) abort_port <= err_port;
      if (err_valid & err_is_wr)  wb_addr    <= err_addr;
    end
  end

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_valid,
  input logic              err_is_wr,
  input logic              ecc_chk_en,
  input logic              rpt_en,
  input logic              clr_valid,
  input logic [1:0]        clr_mask,
  input logic [1:0]        sts,
  input logic              irq,
  input logic [ADDR_W-1:0] slot0_addr,
  input logic [ADDR_W-1:0] slot1_addr,
  input logic              abort_valid,
  input logic              wb_regen
);

  p_set_needs_report_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !$past(sts[0])) |-> $past(err_valid && rpt_en));

  p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> $past(err_valid && !err_is_wr && ecc_chk_en));

  p_wb_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_is_wr) |=> wb_regen);

  p_fill_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !$past(sts[1])) |-> $past(sts[0]));

  p_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && $past(sts[0])) |-> $stable(slot0_addr));

  p_slot1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && $past(sts[1])) |-> $stable(slot1_addr));

  p_no_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_en && !irq) |=> !irq);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_mask[0] && !err_valid) |=> !sts[0]);

  p_clear_wins_not_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_mask[0] && !sts[0] && err_valid && rpt_en) |=> sts[0]);

endmodule

bind ecc_err_log ecc_err_log_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_is_wr(err_is_wr),
  .ecc_chk_en(ecc_chk_en), .rpt_en(rpt_en), .clr_valid(clr_valid),
  .clr_mask(clr_mask), .sts(sts), .irq(irq), .slot0_addr(slot0_addr),
  .slot1_addr(slot1_addr), .abort_valid(abort_valid), .wb_regen(wb_regen)
);

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  localparam int AW = 32;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_valid = 1'b0;
  logic [AW-1:0] err_addr = '0;
  logic err_is_wr = 1'b0, err_is_dma = 1'b0;
  logic [PW-1:0] err_port = '0;
  logic ecc_chk_en = 1'b1, rpt_en = 1'b1;
  logic clr_valid = 1'b0;
  logic [1:0] clr_mask = 2'b00;
  logic [1:0] sts, slot0_type, slot1_type;
  logic irq, abort_valid, wb_regen;
  logic [AW-1:0] slot0_addr, slot1_addr, wb_addr;
  logic [PW-1:0] abort_port;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ecc_err_log #(.ADDR_W(AW), .PORT_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_addr(err_addr),
    .err_is_wr(err_is_wr), .err_is_dma(err_is_dma), .err_port(err_port),
    .ecc_chk_en(ecc_chk_en), .rpt_en(rpt_en), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .sts(sts), .irq(irq), .slot0_type(slot0_type),
    .slot0_addr(slot0_addr), .slot1_type(slot1_type), .slot1_addr(slot1_addr),
    .abort_valid(abort_valid), .abort_port(abort_port), .wb_regen(wb_regen),
    .wb_addr(wb_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic err_cycle(input logic [AW-1:0] a, input logic wr, input logic dma,
                           input logic [PW-1:0] p, input logic cv, input logic [1:0] cm);
    err_valid = 1'b1; err_addr = a; err_is_wr = wr; err_is_dma = dma; err_port = p;
    clr_valid = cv; clr_mask = cm;
    @(negedge clk);
    err_valid = 1'b0; clr_valid = 1'b0; clr_mask = 2'b00;
  endtask

  task automatic clear(input logic [1:0] m);
    clr_valid = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 sts", sts, 2'b00);
    chk("R1 irq", irq, 0);
    chk("R1 abort", abort_valid, 0);
    chk("R1 wb", wb_regen, 0);
  endtask

  task automatic t_read_err;
    err_cycle(32'h0000_1000, 0, 0, 3'd2, 0, 2'b00);
    chk("R2 sts", sts, 2'b01);
    chk("R2 irq", irq, 1);
    chk("R2 addr", slot0_addr, 32'h0000_1000);
    chk("R10 type read queue", slot0_type, 2'b00);
    chk("R3 abort", abort_valid, 1);
    chk("R3 port", abort_port, 3'd2);
    chk("R4 no wb on read", wb_regen, 0);
    @(negedge clk);
    chk("R3 one-cycle abort", abort_valid, 0);
    clear(2'b01);
    chk("R8 cleared", sts, 2'b00);
    chk("R8 irq low", irq, 0);
  endtask

  task automatic t_write_err;
    err_cycle(32'hCAFE_0040, 1, 1, 3'd5, 0, 2'b00);
    chk("R4 wb", wb_regen, 1);
    chk("R4 wb addr", wb_addr, 32'hCAFE_0040);
    chk("R3 no abort on write", abort_valid, 0);
    chk("R10 type write dma", slot0_type, 2'b11);
    @(negedge clk);
    chk("R4 one-cycle wb", wb_regen, 0);
    clear(2'b11);
  endtask

  task automatic t_fill;
    err_cycle(32'h0000_0100, 0, 1, 3'd1, 0, 2'b00);
    chk("R10 type read dma", slot0_type, 2'b01);
    err_cycle(32'h0000_0200, 1, 0, 3'd3, 0, 2'b00);
    chk("R5 second to slot1", sts, 2'b11);
    chk("R5 slot1 addr", slot1_addr, 32'h0000_0200);
    chk("R10 type write queue", slot1_type, 2'b10);
    err_cycle(32'h0000_0300, 0, 0, 3'd6, 0, 2'b00);
    chk("R6 sts full", sts, 2'b11);
    chk("R6 slot0 kept", slot0_addr, 32'h0000_0100);
    chk("R6 slot1 kept", slot1_addr, 32'h0000_0200);
    chk("R6 abort still", abort_valid, 1);
    chk("R6 abort port", abort_port, 3'd6);
    err_cycle(32'h0000_0400, 1, 0, 3'd0, 0, 2'b00);
    chk("R6 wb still", wb_regen, 1);
    chk("R6 slot1 type kept", slot1_type, 2'b10);
    clear(2'b01);
    chk("R8 partial clear", sts, 2'b10);
    chk("R8 irq held", irq, 1);
    err_cycle(32'h0000_0500, 0, 0, 3'd1, 0, 2'b00);
    chk("R5 refill slot0", sts, 2'b11);
    chk("R5 refill addr", slot0_addr, 32'h0000_0500);
    clear(2'b00);
    chk("R8 zero mask", sts, 2'b11);
    clear(2'b11);
    chk("R8 all clear", irq, 0);
  endtask

  task automatic t_no_report;
    rpt_en = 1'b0;
    err_cycle(32'h0000_0600, 0, 0, 3'd4, 0, 2'b00);
    chk("R7 no log", sts, 2'b00);
    chk("R7 no irq", irq, 0);
    chk("R7 abort", abort_valid, 1);
    rpt_en = 1'b1;
    ecc_chk_en = 1'b0;
    err_cycle(32'h0000_0700, 0, 0, 3'd4, 0, 2'b00);
    chk("R3 no abort chk off", abort_valid, 0);
    ecc_chk_en = 1'b1;
    clear(2'b11);
  endtask

  task automatic t_collide;
    err_cycle(32'h0000_0800, 0, 0, 3'd2, 1, 2'b11);
    chk("R9 capture wins", sts, 2'b01);
    chk("R9 addr", slot0_addr, 32'h0000_0800);
    chk("R9 abort", abort_valid, 1);
    err_cycle(32'h0000_0900, 0, 0, 3'd3, 1, 2'b01);
    chk("R9 pre-clear choice", sts, 2'b10);
    chk("R9 slot1 addr", slot1_addr, 32'h0000_0900);
    clear(2'b11);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_read_err;
        t_write_err;
        t_fill;
        t_no_report;
        t_collide;
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule